// File: doc/BRIEF.md
# I2C SCL Stuck-Low Watchdog

This block guards an I2C controller against a clock line that some device holds low indefinitely. It watches a synchronised copy of SCL and measures how long the line stays low, in units of a tick strobe supplied by an external prescaler. Software sets the limit through one 8-bit configuration byte. Bit 7 of that byte turns the watchdog on, and bits 6..0 give a count N. The limit is N+1 ticks. The internal counter restarts on every SCL transition, in either direction.

The watchdog runs only while the controller acts as bus master or is trying to issue a START condition. If SCL stays low for the full limit, the block latches a bus error. On a bus error it presents status code 90h, raises an interrupt and tells the pad logic to release both SDA and SCL. The error state holds until the block reset is applied. Reading the status does not clear it.

Top module: `scl_lowwatch`

## Requirements
- R1: After reset the configuration byte is FFh: the watchdog is enabled with N=127. A line held low raises no error after 127 ticks and raises one after the 128th tick.
- R2: While configuration bit 7 is 0, no amount of low time raises an error.
- R3: With bit 7 set and SCL held low, the error appears in the cycle after the (N+1)th tick is sampled and not earlier. N is configuration bits 6..0, so N=0 needs one tick.
- R4: A rising SCL transition reloads the counter, so the low time before it does not count toward the limit.
- R5: A falling SCL transition also reloads the counter. Ticks that arrive while SCL is high are not counted.
- R6: The counter runs only while `master_mode` or `start_req` is 1. Otherwise it stays loaded and no error is raised.
- R7: Without an error, `err_status` is 00h and `irq` and `drv_release` are 0. With an error, `err_status` is 90h and `irq` and `drv_release` are 1.
- R8: Once raised, the error stays until `rst_n` is asserted. SCL activity, ticks, configuration writes and mode changes do not clear it.
- R9: A configuration write reloads the counter from the written count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; the only way to clear a bus error |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte: bit 7 enables the watchdog, bits 6..0 hold N |
| scl_in | input | 1 | Raw SCL line level, asynchronous |
| tick | input | 1 | One-cycle base-unit strobe from the prescaler |
| master_mode | input | 1 | Controller currently owns the bus as master |
| start_req | input | 1 | Controller is attempting a START condition |
| err_status | output | 8 | 90h on bus error, otherwise 00h |
| irq | output | 1 | Interrupt request, high while the error is held |
| drv_release | output | 1 | Forces the SDA and SCL drivers off, high while the error is held |

## Verification
A change on `scl_in` passes through two synchroniser flops. It takes effect at the third rising edge after it is driven. The bench therefore waits four cycles after every SCL change before it sends ticks. A tick is counted at the edge where it is high. When that tick completes the limit, the error register sets on the same edge, and all three outputs show the error at the next falling edge. The bench samples exactly there. A configuration write takes effect at the edge that captures it. Both the directed and the random cases compare the outputs, one cycle after the last tick, against an expected value that a bench function computes from N, the enable bit, the mode inputs and the number of ticks sent while the line was low.

// File: rtl/sclw_pkg.sv
`timescale 1ns/1ps
package sclw_pkg;
    localparam int VAL_W = 7;
    localparam int CFG_W = VAL_W + 1;
    localparam logic [CFG_W-1:0] CFG_RESET = 8'hFF;
    localparam logic [7:0] STATUS_BUS_ERR = 8'h90;
    localparam logic [7:0] STATUS_OK = 8'h00;

    typedef struct packed {
        logic [VAL_W-1:0] cnt;
        logic             err;
    } tmr_state_t;
endpackage

// File: rtl/sclw_sync.sv
`timescale 1ns/1ps
module sclw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    output logic scl_hi,
    output logic scl_edge
);
    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[PIPE_W-2:0], scl_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign scl_hi   = pipe_q[STAGES-1];
    assign scl_edge = pipe_q[STAGES-1] ^ pipe_q[STAGES];
endmodule

// File: rtl/sclw_cfg.sv
`timescale 1ns/1ps
module sclw_cfg
    import sclw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             cfg_en,
    output logic [VAL_W-1:0] cfg_val_next
);
    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_we ? cfg_wdata : cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg_en       = cfg_q[CFG_W-1];
    assign cfg_val_next = cfg_d[VAL_W-1:0];
endmodule

// File: rtl/sclw_timer.sv
`timescale 1ns/1ps
module sclw_timer
    import sclw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_we,
    input  logic [VAL_W-1:0] cfg_val_next,
    input  logic             scl_hi,
    input  logic             scl_edge,
    input  logic             tick,
    input  logic             active_mode,
    output logic             err
);
    tmr_state_t st_d, st_q;
    logic       run;

    always_comb begin
        st_d = st_q;
        run  = cfg_en && active_mode && !st_q.err;
        if (!st_q.err) begin
            if (!run || scl_edge || cfg_we) begin
                st_d.cnt = cfg_val_next;
            end else if (!scl_hi && tick) begin
                if (st_q.cnt == '0) st_d.err = 1'b1;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '1, err: 1'b0};
        else        st_q <= st_d;
    end

    assign err = st_q.err;
endmodule

// File: rtl/scl_lowwatch.sv
`timescale 1ns/1ps
module scl_lowwatch
    import sclw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       scl_in,
    input  logic       tick,
    input  logic       master_mode,
    input  logic       start_req,
    output logic [7:0] err_status,
    output logic       irq,
    output logic       drv_release
);
    logic             scl_hi;
    logic             scl_edge;
    logic             cfg_en;
    logic [VAL_W-1:0] cfg_val_next;
    logic             err;

    sclw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .scl_hi   (scl_hi),
        .scl_edge (scl_edge)
    );

    sclw_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_en       (cfg_en),
        .cfg_val_next (cfg_val_next)
    );

    sclw_timer u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_en       (cfg_en),
        .cfg_we       (cfg_we),
        .cfg_val_next (cfg_val_next),
        .scl_hi       (scl_hi),
        .scl_edge     (scl_edge),
        .tick         (tick),
        .active_mode  (master_mode | start_req),
        .err          (err)
    );

    assign err_status  = err ? STATUS_BUS_ERR : STATUS_OK;
    assign irq         = err;
    assign drv_release = err;
endmodule

// File: rtl/sclw_chk.sv
`timescale 1ns/1ps
module sclw_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       master_mode,
    input logic       start_req,
    input logic [7:0] err_status,
    input logic       irq,
    input logic       drv_release,
    input logic       en,
    input logic       scl_hi
);
    a_r7_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (err_status == 8'h90 && drv_release));

    a_r7_quiet_when_ok: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (err_status == 8'h00 && !drv_release));

    a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> irq);

    a_r2_disabled_no_error: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !en) |=> !irq);

    a_r6_idle_no_error: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !master_mode && !start_req) |=> !irq);

    a_r3_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !tick) |=> !irq);

    a_r5_high_no_error: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && scl_hi) |=> !irq);
endmodule

bind scl_lowwatch sclw_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .master_mode (master_mode),
    .start_req   (start_req),
    .err_status  (err_status),
    .irq         (irq),
    .drv_release (drv_release),
    .en          (cfg_en),
    .scl_hi      (scl_hi)
);

// File: tb/sim_scl_lowwatch.sv
`timescale 1ns/1ps
module sim_scl_lowwatch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       scl_in = 1'b1;
    logic       tick = 1'b0;
    logic       master_mode = 1'b1;
    logic       start_req = 1'b0;
    logic [7:0] err_status;
    logic       irq;
    logic       drv_release;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    scl_lowwatch u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .scl_in(scl_in), .tick(tick), .master_mode(master_mode),
        .start_req(start_req), .err_status(err_status), .irq(irq),
        .drv_release(drv_release)
    );

    function automatic bit exp_err(input bit en, input bit m, input bit s,
                                   input int val, input int nticks);
        return en && (m || s) && (nticks >= val + 1);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_we = 1'b0; tick = 1'b0; scl_in = 1'b1;
        master_mode = 1'b1; start_req = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(1);
            tick = 1'b0; step(1);
        end
    endtask

    task automatic set_scl(input logic v);
        scl_in = v;
        step(4);
    endtask

    task automatic write_cfg(input logic [7:0] b);
        cfg_we = 1'b1; cfg_wdata = b;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic check_err(input string req, input bit exp);
        logic [7:0] es;
        checks++;
        es = exp ? 8'h90 : 8'h00;
        if (irq !== exp || drv_release !== exp || err_status !== es) begin
            errors++;
            $display("FAIL %s: irq=%0b rel=%0b status=%02h expected irq=%0b rel=%0b status=%02h",
                     req, irq, drv_release, err_status, exp, exp, es);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        check_err("R7 reset state", 1'b0);

        // R1: default limit is 128 ticks
        set_scl(1'b0);
        ticks(127);
        check_err("R1 default 127 ticks", 1'b0);
        ticks(1);
        check_err("R1 default 128th tick", 1'b1);
        check_err("R7 error outputs", 1'b1);

        // R8: nothing but reset clears the error
        set_scl(1'b1);
        ticks(3);
        write_cfg(8'h00);
        master_mode = 1'b0;
        step(3);
        check_err("R8 sticky", 1'b1);
        do_reset();
        check_err("R8 cleared by reset", 1'b0);

        // R3: exact limit N+1
        write_cfg(8'h83);
        set_scl(1'b0);
        ticks(3);
        check_err("R3 N=3 after 3 ticks", 1'b0);
        ticks(1);
        check_err("R3 N=3 after 4 ticks", 1'b1);
        do_reset();
        write_cfg(8'h80);
        set_scl(1'b0);
        step(5);
        check_err("R3 N=0 no tick", 1'b0);
        ticks(1);
        check_err("R3 N=0 one tick", 1'b1);

        // R2: disabled
        do_reset();
        write_cfg(8'h05);
        set_scl(1'b0);
        ticks(20);
        check_err("R2 disabled", 1'b0);

        // R4 / R5: reload on both edges, high ticks ignored
        do_reset();
        write_cfg(8'h84);
        set_scl(1'b0);
        ticks(4);
        set_scl(1'b1);
        set_scl(1'b0);
        ticks(4);
        check_err("R4 rising edge reload", 1'b0);
        set_scl(1'b1);
        ticks(10);
        check_err("R5 ticks while high", 1'b0);
        set_scl(1'b0);
        ticks(4);
        check_err("R5 falling edge reload", 1'b0);
        ticks(1);
        check_err("R5 limit after reload", 1'b1);

        // R6: mode gating, START attempt
        do_reset();
        write_cfg(8'h82);
        master_mode = 1'b0;
        set_scl(1'b0);
        ticks(10);
        check_err("R6 idle mode", 1'b0);
        start_req = 1'b1;
        ticks(2);
        check_err("R6 start_req partial", 1'b0);
        ticks(1);
        check_err("R6 start_req limit", 1'b1);

        // R9: write reloads the counter
        do_reset();
        write_cfg(8'h89);
        set_scl(1'b0);
        ticks(8);
        write_cfg(8'h89);
        ticks(9);
        check_err("R9 reload by write", 1'b0);
        ticks(1);
        check_err("R9 limit after write", 1'b1);

        // random trials
        void'($urandom(32'h5C1_0A7));
        for (int t = 0; t < 40; t++) begin
            int val, n;
            bit en, m, s;
            do_reset();
            val = $urandom_range(0, 7);
            n   = $urandom_range(0, 10);
            en  = ($urandom_range(0, 3) != 0);
            m   = $urandom_range(0, 1);
            s   = $urandom_range(0, 1);
            write_cfg({en, 7'(val)});
            master_mode = m;
            start_req = s;
            set_scl(1'b0);
            ticks(n);
            check_err("R3 random trial", exp_err(en, m, s, val, n));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule